// File: doc/BRIEF.md
# Buffer RAM Signature Initialization Sequencer

This block writes two bytes into the controller's buffer RAM after the host loads a new node identifier. Address 0 receives a fixed signature byte, 0xD1. Address 1 receives the node identifier itself. Host diagnostics read the two locations back to confirm that the controller is alive.

By default the sequence holds off while the network line is active, and writes only once the line goes quiet. When the configuration input `skip_idle_wait` is set, the line-idle hold is lifted for this routine alone, so the signature lands at once whatever the network is doing. Other parts of the micro-program that request a line-idle stall through `prog_sync_req` keep their stall in both settings.

A budget counter tracks the time since the identifier write. If the two writes have not both finished within `BUDGET_CYC` system clocks (3 µs by default), a status flag is set.

The controller has five states:
- **S_IDLE** is the state after reset.
- **S_ARM** waits for permission to write.
- **S_WR_SIG** issues the signature write.
- **S_WR_NID** issues the identifier write.
- **S_DONE** is the finished state.

The transitions are:
- **T_LOAD**: a host identifier write in any state leads to S_ARM.
- **T_GO**: S_ARM leads to S_WR_SIG when writing is allowed.
- **T_STALL**: S_ARM stays in S_ARM while the line holds it off.
- **T_NEXT**: S_WR_SIG leads to S_WR_NID.
- **T_FIN**: S_WR_NID leads to S_DONE.
- **T_REST**: S_DONE and S_IDLE stay where they are.

Top module: `ris_ram_init_seq`

## Requirements
- R1: During and directly after reset, `ram_we`, `init_done` and `budget_expired` are 0.
- R2: When `nid_wr` is sampled high at a clock edge E0, the sequence restarts. If writing is allowed at E1, then between E1 and E2 the block drives `ram_we`=1, `ram_addr`=0 and `ram_wdata`=0xD1.
- R3: In the cycle straight after the signature write, the block drives `ram_we`=1, `ram_addr`=1 and `ram_wdata` equal to the identifier captured with the last `nid_wr`.
- R4: `init_done` rises in the cycle after the identifier write. It stays 1, with `ram_we`=0, until the next `nid_wr`.
- R5: With `skip_idle_wait`=0, no RAM write occurs while `line_busy`=1. The signature write appears in the cycle after the first edge at which `line_busy` is sampled 0.
- R6: With `skip_idle_wait`=1, `line_busy` has no effect on the sequence. The writes follow R2 and R3 with no delay.
- R7: A `nid_wr` that arrives while the sequence runs restarts it with the new value. It also clears `init_done` from the next cycle on.
- R8: `budget_expired` is set if the sequence has not finished within `BUDGET_CYC` cycles after `nid_wr`. It stays set until the next `nid_wr`, and it stays 0 when the writes finish in time.
- R9: `prog_stall` equals `prog_sync_req` AND `line_busy`, whatever the value of `skip_idle_wait`.
- R10: `ram_we` is never asserted with an address other than 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nid_wr | input | 1 | Host write strobe for the node identifier |
| nid_data | input | DATA_W | Node identifier value |
| skip_idle_wait | input | 1 | 1 lifts the line-idle hold inside this routine |
| line_busy | input | 1 | Network line activity |
| prog_sync_req | input | 1 | Line-idle stall request from other micro-program code |
| prog_stall | output | 1 | Stall back to that code |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| init_done | output | 1 | Both bytes written |
| budget_expired | output | 1 | Write budget ran out |

## Verification
The assertions take for granted that every input is synchronous to `clk` and stable around its rising edge. They also assume `nid_wr` is a pulse that can repeat. Several properties exclude a cycle in which `nid_wr` is high, because a strobe in that cycle legitimately overrides the expected next state. The bench therefore changes every input only on the falling edge, and it holds `line_busy` constant across each edge it reasons about. It places restart strobes deliberately, both in the arm state and in the signature-write cycle.

// File: rtl/ris_pkg.sv
`timescale 1ns/1ps
package ris_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ARM    = 3'd1,
        S_WR_SIG = 3'd2,
        S_WR_NID = 3'd3,
        S_DONE   = 3'd4
    } seq_state_t;

    localparam logic [7:0] SIGNATURE_BYTE = 8'hD1;
endpackage

// File: rtl/ris_budget_timer.sv
`timescale 1ns/1ps
module ris_budget_timer #(
    parameter int LIMIT = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic running,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (restart) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (running && !expired) begin
            if (cnt == LAST) begin
                expired <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R8
    AST_EXPIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(running)); // R8
    AST_EXPIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        expired && !restart |=> expired); // R8
endmodule

// File: rtl/ris_sync_gate.sv
`timescale 1ns/1ps
module ris_sync_gate (
    input  logic in_init,
    input  logic skip_idle_wait,
    input  logic line_busy,
    input  logic prog_sync_req,
    output logic init_go,
    output logic prog_stall
);
    always_comb begin
        init_go    = !line_busy || (skip_idle_wait && in_init);
        prog_stall = prog_sync_req && line_busy;
    end
endmodule

// File: rtl/ris_ram_init_seq.sv
`timescale 1ns/1ps
module ris_ram_init_seq
    import ris_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int BUDGET_CYC = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nid_wr,
    input  logic [DATA_W-1:0] nid_data,
    input  logic              skip_idle_wait,
    input  logic              line_busy,
    input  logic              prog_sync_req,
    output logic              prog_stall,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              init_done,
    output logic              budget_expired
);
    localparam logic [ADDR_W-1:0] SIG_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] NID_ADDR = ADDR_W'(1);
    localparam logic [DATA_W-1:0] SIG_VAL  = DATA_W'(SIGNATURE_BYTE);

    seq_state_t        state, state_nx;
    logic [DATA_W-1:0] nid_q;
    logic              init_go;
    logic              in_routine;

    assign in_routine = (state == S_ARM) || (state == S_WR_SIG) || (state == S_WR_NID);

    ris_sync_gate u_gate (
        .in_init        (in_routine),
        .skip_idle_wait (skip_idle_wait),
        .line_busy      (line_busy),
        .prog_sync_req  (prog_sync_req),
        .init_go        (init_go),
        .prog_stall     (prog_stall)
    );

    ris_budget_timer #(.LIMIT(BUDGET_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (nid_wr),
        .running (in_routine),
        .expired (budget_expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nid_q <= '0;
        end else if (nid_wr) begin
            nid_q <= nid_data;
        end
    end

    always_comb begin
        state_nx = state;
        if (nid_wr) begin
            state_nx = S_ARM;                          // T_LOAD
        end else begin
            unique case (state)
                S_IDLE:   state_nx = S_IDLE;           // T_REST
                S_ARM:    state_nx = init_go ? S_WR_SIG : S_ARM; // T_GO / T_STALL
                S_WR_SIG: state_nx = S_WR_NID;         // T_NEXT
                S_WR_NID: state_nx = S_DONE;           // T_FIN
                S_DONE:   state_nx = S_DONE;           // T_REST
                default:  state_nx = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        init_done = 1'b0;
        unique case (state)
            S_IDLE, S_ARM: begin
            end
            S_WR_SIG: begin
                ram_we    = 1'b1;
                ram_addr  = SIG_ADDR;
                ram_wdata = SIG_VAL;
            end
            S_WR_NID: begin
                ram_we    = 1'b1;
                ram_addr  = NID_ADDR;
                ram_wdata = nid_q;
            end
            S_DONE: init_done = 1'b1;
            default: begin
            end
        endcase
    end

    AST_SIG_THEN_NID: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr == SIG_ADDR && !nid_wr) |=> (ram_we && ram_addr == NID_ADDR)); // R3
    AST_NID_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr == NID_ADDR && !nid_wr) |=> init_done); // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !nid_wr) |=> (init_done && !ram_we)); // R4
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARM && !skip_idle_wait && line_busy && !nid_wr) |=> !ram_we); // R5
    AST_BYPASS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARM && skip_idle_wait && !nid_wr) |=> (ram_we && ram_addr == SIG_ADDR)); // R6
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        nid_wr |=> (!init_done && !ram_we)); // R7
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr == SIG_ADDR || ram_addr == NID_ADDR)); // R10
endmodule

// File: tb/sim_ris_ram_init_seq.sv
`timescale 1ns/1ps
module sim_ris_ram_init_seq;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int BUDGET = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nid_wr = 1'b0;
    logic [DATA_W-1:0] nid_data = '0;
    logic skip_idle_wait = 1'b0;
    logic line_busy = 1'b0;
    logic prog_sync_req = 1'b0;
    logic prog_stall, ram_we, init_done, budget_expired;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int bad_addr = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ris_ram_init_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUDGET_CYC(BUDGET)) u0 (
        .clk(clk), .rst_n(rst_n), .nid_wr(nid_wr), .nid_data(nid_data),
        .skip_idle_wait(skip_idle_wait), .line_busy(line_busy),
        .prog_sync_req(prog_sync_req), .prog_stall(prog_stall),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .init_done(init_done), .budget_expired(budget_expired)
    );

    // {skip_idle_wait, line_busy, node id}
    localparam logic [9:0] VEC [0:5] = '{
        {1'b1, 1'b0, 8'h5A}, {1'b1, 1'b1, 8'h3C}, {1'b0, 1'b0, 8'hFF},
        {1'b0, 1'b1, 8'h01}, {1'b1, 1'b1, 8'h00}, {1'b0, 1'b1, 8'hA7}
    };

    always @(negedge clk) if (rst_n && ram_we && ram_addr > 1) bad_addr++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_nid(input logic [DATA_W-1:0] v);
        @(negedge clk); nid_wr = 1'b1; nid_data = v;
        @(negedge clk); nid_wr = 1'b0;
    endtask

    task automatic expect_writes(input logic [DATA_W-1:0] v, input string req);
        int a;
        int e;
        @(negedge clk);
        a = int'({ram_we, ram_addr, ram_wdata}); e = int'({1'b1, 11'd0, 8'hD1});
        chk(a == e, req, "signature write (R2)", a, e);
        @(negedge clk);
        a = int'({ram_we, ram_addr, ram_wdata}); e = int'({1'b1, 11'd1, v});
        chk(a == e, req, "node id write (R3)", a, e);
        @(negedge clk);
        chk(init_done && !ram_we, req, "done after writes (R4)", int'({init_done, ram_we}), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!ram_we && !init_done && !budget_expired, "R1", "outputs in reset",
            int'({ram_we, init_done, budget_expired}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ram_we && !init_done && !budget_expired, "R1", "outputs after reset",
            int'({ram_we, init_done, budget_expired}), 0);

        foreach (VEC[i]) begin
            skip_idle_wait = VEC[i][9];
            line_busy      = VEC[i][8];
            pulse_nid(VEC[i][7:0]);
            if (VEC[i][8] && !VEC[i][9]) begin
                repeat (4) begin
                    @(negedge clk);
                    chk(!ram_we && !init_done, "R5", "held while line busy",
                        int'({ram_we, init_done}), 0);
                end
                line_busy = 1'b0;
            end
            expect_writes(VEC[i][7:0], VEC[i][9] ? "R6" : "R2");
            chk(!budget_expired, "R8", "no expiry when in time", int'(budget_expired), 0);
        end

        // R4: done sticky while line toggles
        skip_idle_wait = 1'b0;
        line_busy = 1'b1;
        repeat (3) @(negedge clk);
        chk(init_done && !ram_we, "R4", "done held", int'({init_done, ram_we}), 2);
        line_busy = 1'b0;

        // R7: restart while armed and held
        line_busy = 1'b1;
        pulse_nid(8'h11);
        chk(!init_done, "R7", "done cleared by new strobe", int'(init_done), 0);
        repeat (2) @(negedge clk);
        pulse_nid(8'h22);
        line_busy = 1'b0;
        expect_writes(8'h22, "R7");

        // R7: restart during signature write
        skip_idle_wait = 1'b1;
        pulse_nid(8'h33);
        pulse_nid(8'h44);
        expect_writes(8'h44, "R7");

        // R8: budget expiry
        skip_idle_wait = 1'b0;
        line_busy = 1'b1;
        pulse_nid(8'h55);
        repeat (BUDGET - 50) @(negedge clk);
        chk(!budget_expired, "R8", "not yet expired", int'(budget_expired), 0);
        repeat (100) @(negedge clk);
        chk(budget_expired && !ram_we, "R8", "expired while held",
            int'({budget_expired, ram_we}), 2);
        line_busy = 1'b0;
        expect_writes(8'h55, "R8");
        chk(budget_expired, "R8", "expiry sticky", int'(budget_expired), 1);
        skip_idle_wait = 1'b1;
        pulse_nid(8'h66);
        chk(!budget_expired, "R8", "expiry cleared by strobe", int'(budget_expired), 0);
        expect_writes(8'h66, "R6");

        // R9: other stall unaffected by bypass
        @(negedge clk);
        prog_sync_req = 1'b1; line_busy = 1'b1; skip_idle_wait = 1'b1;
        #1 chk(prog_stall, "R9", "stall with bypass set", int'(prog_stall), 1);
        skip_idle_wait = 1'b0;
        #1 chk(prog_stall, "R9", "stall with bypass clear", int'(prog_stall), 1);
        line_busy = 1'b0;
        #1 chk(!prog_stall, "R9", "no stall when idle", int'(prog_stall), 0);
        prog_sync_req = 1'b0;

        chk(bad_addr == 0, "R10", "writes outside 0..1", bad_addr, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule